// File: doc/BRIEF.md
# Byte-Serial 32-bit Register Port

This block gives a byte-wide framed stream channel a single 32-bit register behind it. A host loads the register by sending a four-byte packet, least significant byte first, and reads it back as a four-byte response in the same byte order. Each direction moves one byte per cycle at most. A byte moves only when the source side offers it and the destination side is ready for it. Each direction also has its own enable, which comes from the channel address decode.

On the write side, the first three bytes of a packet are collected in a staging word. The visible register changes only when the fourth byte is accepted, and then all 32 bits change at once, so the register never shows a half-written value. A start-of-frame marker on an incoming byte always restarts assembly at byte 0. On the read side, a byte index selects one lane of the live register value. Start-of-frame is marked on byte 0 and end-of-frame on byte 3. Both ready outputs come straight from flip-flops.

Top module: `bsreg_port`

## Requirements
- R1: After reset, reg_value is 0, wr_ready and rd_valid are low, and the read index points at byte 0, so rd_sof is 1 and rd_eof is 0.
- R2: A write byte is accepted only in a cycle where wr_en, wr_valid and wr_ready are all 1. A read byte is delivered only in a cycle where rd_en, rd_valid and rd_ready are all 1.
- R3: Accepted bytes b0, b1, b2, b3, in that order, load reg_value with {b3,b2,b1,b0}. Byte k lands in bits [8k+7:8k].
- R4: reg_value holds its old value while the first three bytes of a packet are accepted. It takes the new word on the clock edge that accepts the fourth byte, and changes at no other edge except reset.
- R5: An accepted byte with wr_sof = 1 is taken as byte 0 of a new packet, whatever the count of bytes taken before it.
- R6: Read bytes come out in little-endian order: byte k is reg_value[8k+7:8k]. rd_sof is 1 only with byte 0 and rd_eof is 1 only with byte 3. After byte 3 is delivered, the index returns to byte 0.
- R7: In a cycle with no transfer, the position is held: wr_valid low keeps the write count, and rd_ready low or rd_en low keeps the read byte, rd_sof and rd_eof.
- R8: wr_ready equals wr_en of the previous cycle, and rd_valid equals rd_en of the previous cycle. Both come from registers.
- R9: Bytes offered while wr_en is 0 are ignored. They neither change reg_value nor advance the write count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write-direction channel enable |
| wr_valid | input | 1 | Host has a write byte on wr_data |
| wr_sof | input | 1 | Write byte is the first of its packet |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Block can take a write byte (registered) |
| rd_en | input | 1 | Read-direction channel enable |
| rd_ready | input | 1 | Host can take a read byte |
| rd_valid | output | 1 | Block offers a read byte (registered) |
| rd_sof | output | 1 | Read byte is byte 0 |
| rd_eof | output | 1 | Read byte is byte 3 |
| rd_data | output | 8 | Read byte |
| reg_value | output | 32 | Current register contents |

## Verification
The write path is tried with four distinct byte values sent back to back. This catches byte-order and lane-swap faults. The same values are then sent with gaps in wr_valid, which tells a held count from one that advances on idle cycles. A packet that is cut off and followed by a fresh start-of-frame shows whether assembly restarts. Bytes offered while the channel is disabled, followed by an enabled packet with no start-of-frame marker, show that the ignored bytes left both the register and the count unchanged. Read-back is done without stalls, with rd_ready stalls and with rd_en drops, so a correct byte index and correct markers can be told apart from ones that slip during a pause.

// File: rtl/bsreg_pkg.sv
package bsreg_pkg;
   typedef enum logic {
      STG_SHIFT = 1'b0,
      STG_INDEX = 1'b1
   } stage_style_e;

   function automatic int unsigned lanes_of(input int unsigned word_w, input int unsigned lane_w);
      return word_w / lane_w;
   endfunction
endpackage

// File: rtl/bsreg_wr_asm.sv
module bsreg_wr_asm
   import bsreg_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned BYTE_W = 8,
   parameter stage_style_e STYLE = STG_SHIFT,
   localparam int unsigned NB    = lanes_of(REG_W, BYTE_W),
   localparam int unsigned CW    = (NB > 1) ? $clog2(NB) : 1,
   localparam int unsigned SW    = REG_W - BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_valid,
   input  logic              wr_sof,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              commit_vld,
   output logic [REG_W-1:0]  commit_word
);
   logic          rdy_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] pos;
   logic [SW-1:0] stage_q;
   logic          take;
   logic          last;

   assign take = wr_en & wr_valid & rdy_q;
   assign pos  = wr_sof ? '0 : cnt_q;
   assign last = (pos == CW'(NB - 1));

   always_ff @(posedge clk) begin
      if (rst) rdy_q <= 1'b0;
      else     rdy_q <= wr_en;
   end

   always_ff @(posedge clk) begin
      if (rst)             cnt_q <= '0;
      else if (take) begin
         if (last)         cnt_q <= '0;
         else              cnt_q <= pos + CW'(1);
      end
   end

   generate
      if (STYLE == STG_SHIFT) begin : g_shift
         if (SW > BYTE_W) begin : g_wide
            always_ff @(posedge clk) begin
               if (rst)               stage_q <= '0;
               else if (take && !last) stage_q <= {wr_data, stage_q[SW-1:BYTE_W]};
            end
         end else begin : g_narrow
            always_ff @(posedge clk) begin
               if (rst)               stage_q <= '0;
               else if (take && !last) stage_q <= wr_data;
            end
         end
      end else begin : g_index
         for (genvar g = 0; g < NB - 1; g++) begin : g_lane
            always_ff @(posedge clk) begin
               if (rst)
                  stage_q[g*BYTE_W +: BYTE_W] <= '0;
               else if (take && (pos == CW'(g)))
                  stage_q[g*BYTE_W +: BYTE_W] <= wr_data;
            end
         end
      end
   endgenerate

   assign wr_ready    = rdy_q;
   assign commit_vld  = take & last;
   assign commit_word = {wr_data, stage_q};
endmodule

// File: rtl/bsreg_word_reg.sv
module bsreg_word_reg #(
   parameter int unsigned       REG_W     = 32,
   parameter logic [REG_W-1:0]  RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             commit_vld,
   input  logic [REG_W-1:0] commit_word,
   output logic [REG_W-1:0] word_q
);
   always_ff @(posedge clk) begin
      if (rst)             word_q <= RESET_VAL;
      else if (commit_vld) word_q <= commit_word;
   end
endmodule

// File: rtl/bsreg_rd_sel.sv
module bsreg_rd_sel
   import bsreg_pkg::*;
#(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NB    = lanes_of(REG_W, BYTE_W),
   localparam int unsigned CW    = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              rd_ready,
   input  logic [REG_W-1:0]  word,
   output logic              rd_valid,
   output logic              rd_sof,
   output logic              rd_eof,
   output logic [BYTE_W-1:0] rd_data
);
   logic              vld_q;
   logic [CW-1:0]     idx_q;
   logic              give;
   logic [BYTE_W-1:0] lane [NB];

   assign give = rd_en & vld_q & rd_ready;

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= rd_en;
   end

   always_ff @(posedge clk) begin
      if (rst)       idx_q <= '0;
      else if (give) idx_q <= (idx_q == CW'(NB - 1)) ? '0 : idx_q + CW'(1);
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane[g] = word[g*BYTE_W +: BYTE_W];
   end

   assign rd_data  = lane[idx_q];
   assign rd_sof   = (idx_q == '0);
   assign rd_eof   = (idx_q == CW'(NB - 1));
   assign rd_valid = vld_q;
endmodule

// File: rtl/bsreg_port.sv
module bsreg_port
   import bsreg_pkg::*;
#(
   parameter int unsigned  REG_W  = 32,
   parameter int unsigned  BYTE_W = 8,
   parameter stage_style_e STYLE  = STG_SHIFT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_valid,
   input  logic              wr_sof,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_en,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic              rd_sof,
   output logic              rd_eof,
   output logic [BYTE_W-1:0] rd_data,
   output logic [REG_W-1:0]  reg_value
);
   localparam int unsigned NB = lanes_of(REG_W, BYTE_W);

   if (BYTE_W == 0 || (REG_W % BYTE_W) != 0) begin : g_bad_width
      $error("bsreg_port: REG_W must be a whole number of bytes");
   end
   if (NB < 2) begin : g_bad_count
      $error("bsreg_port: at least two bytes per word are required");
   end

   logic             commit_vld;
   logic [REG_W-1:0] commit_word;
   logic [REG_W-1:0] word_q;

   bsreg_wr_asm #(.REG_W(REG_W), .BYTE_W(BYTE_W), .STYLE(STYLE)) wr_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_valid(wr_valid),
      .wr_sof(wr_sof), .wr_data(wr_data), .wr_ready(wr_ready),
      .commit_vld(commit_vld), .commit_word(commit_word)
   );

   bsreg_word_reg #(.REG_W(REG_W)) reg_i (
      .clk(clk), .rst(rst), .commit_vld(commit_vld),
      .commit_word(commit_word), .word_q(word_q)
   );

   bsreg_rd_sel #(.REG_W(REG_W), .BYTE_W(BYTE_W)) rd_i (
      .clk(clk), .rst(rst), .rd_en(rd_en), .rd_ready(rd_ready),
      .word(word_q), .rd_valid(rd_valid), .rd_sof(rd_sof),
      .rd_eof(rd_eof), .rd_data(rd_data)
   );

   assign reg_value = word_q;
endmodule

// File: rtl/bsreg_port_chk.sv
module bsreg_port_chk #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NB    = REG_W / BYTE_W,
   localparam int unsigned CW    = (NB > 1) ? $clog2(NB) : 1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              wr_valid,
   input logic              wr_sof,
   input logic              wr_ready,
   input logic              rd_en,
   input logic              rd_ready,
   input logic              rd_valid,
   input logic              rd_sof,
   input logic              rd_eof,
   input logic [BYTE_W-1:0] rd_data,
   input logic [REG_W-1:0]  reg_value
);
   logic          acc;
   logic          give;
   logic [CW-1:0] seen_q;
   logic [CW-1:0] seen_pos;
   logic          fourth;

   assign acc      = wr_en & wr_valid & wr_ready;
   assign give     = rd_en & rd_valid & rd_ready;
   assign seen_pos = wr_sof ? '0 : seen_q;
   assign fourth   = acc && (seen_pos == CW'(NB - 1));

   always_ff @(posedge clk) begin
      if (rst)       seen_q <= '0;
      else if (acc)  seen_q <= fourth ? '0 : seen_pos + CW'(1);
   end

   AST_WR_READY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (wr_ready == $past(wr_en))); // R8
   AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (rd_valid == $past(rd_en))); // R8
   AST_COMMIT_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
      (!$stable(reg_value) && !$past(rst)) |-> $past(fourth)); // R4
   AST_WR_EN_GATE: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(reg_value)); // R9
   AST_MARKERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_sof, rd_eof})); // R6
   AST_RD_WRAP: assert property (@(posedge clk) disable iff (rst)
      (give && rd_eof) |=> rd_sof); // R6
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !give |=> ($stable(rd_sof) && $stable(rd_eof))); // R7
   AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
      (give && rd_sof) |=> !rd_sof); // R2
endmodule

bind bsreg_port bsreg_port_chk #(.REG_W(REG_W), .BYTE_W(BYTE_W)) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_valid(wr_valid), .wr_sof(wr_sof),
   .wr_ready(wr_ready), .rd_en(rd_en), .rd_ready(rd_ready), .rd_valid(rd_valid),
   .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_data(rd_data), .reg_value(reg_value)
);

// File: tb/bsreg_port_tb.sv
`timescale 1ns/1ps
module bsreg_port_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0, wr_valid = 1'b0, wr_sof = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        wr_ready;
   logic        rd_en = 1'b0, rd_ready = 1'b0;
   logic        rd_valid, rd_sof, rd_eof;
   logic [7:0]  rd_data;
   logic [31:0] reg_value;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   bsreg_port dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_valid(wr_valid), .wr_sof(wr_sof),
      .wr_data(wr_data), .wr_ready(wr_ready), .rd_en(rd_en), .rd_ready(rd_ready),
      .rd_valid(rd_valid), .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_data(rd_data),
      .reg_value(reg_value)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic sof, input int gap);
      for (int i = 0; i < gap; i++) begin
         @(negedge clk); wr_valid = 1'b0;
      end
      @(negedge clk);
      wr_valid = 1'b1; wr_data = b; wr_sof = sof;
      @(negedge clk);
      wr_valid = 1'b0; wr_sof = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] w, input int gap, input logic [31:0] old);
      for (int k = 0; k < 4; k++) begin
         send_byte(w[8*k +: 8], k == 0, gap);
         if (k < 3) check(reg_value == old, "R4 partial word visible", reg_value, old);
      end
   endtask

   task automatic read_word(input logic [31:0] exp, input int mode, input string tag);
      int k = 0;
      int cyc = 0;
      @(negedge clk); rd_en = 1'b1; rd_ready = 1'b1;
      while (k < 4 && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (mode == 1) rd_ready = (cyc % 3) != 1;
         if (mode == 2) rd_en = (cyc % 4) > 1;
         #1;
         if (rd_valid && rd_ready && rd_en) begin
            check(rd_data == exp[8*k +: 8], {tag, " byte"}, 32'(rd_data), 32'(exp[8*k +: 8]));
            check(rd_sof == (k == 0) && rd_eof == (k == 3), {tag, " markers"},
                  {30'd0, rd_sof, rd_eof}, {30'd0, k == 0, k == 3});
            k++;
         end else if (rd_en || rd_valid) begin
            check(rd_data == exp[8*k +: 8], "R7 read position held", 32'(rd_data), 32'(exp[8*k +: 8]));
         end
      end
      check(k == 4, {tag, " count"}, 32'(k), 32'd4);
      @(negedge clk); rd_en = 1'b0; rd_ready = 1'b0;
      @(negedge clk);
      check(rd_sof == 1'b1, "R6 index wrapped to byte 0", 32'(rd_sof), 32'd1);
   endtask

   task automatic t_reset();
      check(reg_value == 32'h0, "R1 reg reset", reg_value, 32'h0);
      check(!wr_ready && !rd_valid, "R1 ready/valid low", {wr_ready, rd_valid}, 32'h0);
      check(rd_sof && !rd_eof, "R1 read index at byte 0", {rd_sof, rd_eof}, 32'h2);
   endtask

   task automatic t_ready_follow();
      @(negedge clk); wr_en = 1'b1; rd_en = 1'b1;
      #1;
      check(!wr_ready && !rd_valid, "R8 not yet following", {wr_ready, rd_valid}, 32'h0);
      @(negedge clk);
      check(wr_ready && rd_valid, "R8 follows enables", {wr_ready, rd_valid}, 32'h3);
      rd_en = 1'b0;
      @(negedge clk);
      check(!rd_valid && rd_sof, "R8 rd_valid drops, R2 no delivery without ready", {rd_valid, rd_sof}, 32'h1);
   endtask

   task automatic t_write_basic();
      send_word(32'hA1B2C3D4, 0, 32'h0);
      check(reg_value == 32'hA1B2C3D4, "R3 little-endian write", reg_value, 32'hA1B2C3D4);
   endtask

   task automatic t_write_gaps();
      send_word(32'h0F1E2D3C, 2, 32'hA1B2C3D4);
      check(reg_value == 32'h0F1E2D3C, "R7 write with gaps", reg_value, 32'h0F1E2D3C);
   endtask

   task automatic t_sof_restart();
      send_byte(8'h11, 1'b1, 0);
      send_byte(8'h22, 1'b0, 0);
      check(reg_value == 32'h0F1E2D3C, "R4 cut packet not visible", reg_value, 32'h0F1E2D3C);
      send_word(32'h55667788, 0, 32'h0F1E2D3C);
      check(reg_value == 32'h55667788, "R5 sof restarts assembly", reg_value, 32'h55667788);
   endtask

   task automatic t_wr_en_gate();
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 5; k++) send_byte(8'hE0 + 8'(k), 1'b0, 0);
      check(reg_value == 32'h55667788, "R9 disabled bytes ignored", reg_value, 32'h55667788);
      @(negedge clk); wr_en = 1'b1;
      send_byte(8'h01, 1'b0, 0);
      send_byte(8'h02, 1'b0, 0);
      send_byte(8'h03, 1'b0, 0);
      check(reg_value == 32'h55667788, "R9 count not advanced", reg_value, 32'h55667788);
      send_byte(8'h04, 1'b0, 0);
      check(reg_value == 32'h04030201, "R9 enabled packet after ignored bytes", reg_value, 32'h04030201);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      #1;
      t_reset();
      t_ready_follow();
      t_write_basic();
      read_word(32'hA1B2C3D4, 0, "R6 read plain");
      t_write_gaps();
      read_word(32'h0F1E2D3C, 1, "R7 read ready stalls");
      t_sof_restart();
      read_word(32'h55667788, 2, "R7 read enable drops");
      t_wr_en_gate();
      read_word(32'h04030201, 0, "R2 read after gate");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule